// File: doc/BRIEF.md
# Parallel Flash Buffered-Write Sequencer

This engine programs a 16-bit parallel NOR flash that sits behind a windowed address space, driving every command cycle itself so that software only has to fill a small word buffer and pulse a strobe. For a buffered write it emits the two-cycle unlock prefix, the write-buffer setup command, the word count minus one, the data words at consecutive 16-bit addresses and the commit command. It then re-reads the last programmed address until data bit 7 matches bit 7 of the last word written.

A sector erase follows the same pattern: prefix, erase setup, a second prefix and the erase command at the sector base. The engine then polls the sector base until it reads all ones. Each flash access is one request/acknowledge transaction on a simple bus. The engine finishes with a one-cycle done pulse. It raises a one-cycle error pulse instead if the request is malformed or if polling runs past a programmable limit.

Top module: `flash_prog_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `bus_req`, `done` and `error` are all low.
- R2: Every operation starts with an unlock prefix: data 0x00AA written at address 0x00408, then data 0x0055 written at address 0x00400.
- R3: With `op_erase`=0, the prefix is followed by these writes, in order: 0x0025 at the window base 0x60000; then `word_count`-1 at 0x60000; then buffer word i at address (0x60000 OR `byte_offset`) + 2*i, for i counting up from 0; then 0x0029 at 0x60000.
- R4: After the commit, the engine reads (`bus_we`=0) the address of the last data word. Only bit 7 of the read data is compared, against bit 7 of the last buffer word; a match ends the operation with `done`.
- R5: With `op_erase`=1, the writes are: prefix, 0x0080 at 0x00408, prefix, 0x0030 at 0x60000. The engine then reads 0x60000 until the read returns 0xFFFF and then pulses `done`. `word_count` is not used.
- R6: A write request with `word_count` of 0 or above 32 raises `error` in the following cycle. It leaves the engine idle and issues no bus request.
- R7: When `poll_limit` consecutive polling reads all report "not finished", the engine pulses `error` instead of `done` and returns to idle.
- R8: Only one access is outstanding at a time. While `bus_req` is high and `bus_ack` is low, the address, data and direction are held unchanged.
- R9: A `start` pulse that arrives while the engine is busy is ignored, and the running sequence continues unchanged.
- R10: `done` and `error` are single-cycle pulses, never both high at once, and `busy` is already low in the cycle either one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| op_erase | input | 1 | 1 = sector erase, 0 = buffered write |
| byte_offset | input | 18 | Byte offset of the first data word inside the window |
| word_count | input | 6 | Number of buffer words to program |
| poll_limit | input | 16 | Maximum number of unsuccessful polling reads |
| buf_we | input | 1 | Buffer load strobe |
| buf_idx | input | 5 | Buffer load index |
| buf_wdata | input | 16 | Buffer load data |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | 20 | Access byte address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access accepted; read data valid in the same cycle |
| bus_rdata | input | 16 | Read data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Operation finished successfully (pulse) |
| error | output | 1 | Request rejected or polling limit reached (pulse) |

## Verification
The assertions take for granted that `start` is a pulse one cycle wide. They also assume that `bus_ack` is raised only while `bus_req` is high and that the buffer is not reloaded while `busy` is high. The stimulus keeps to these assumptions in the following ways. The start strobe is driven for one cycle only. The bus responder raises its acknowledge for one cycle, and only in answer to a pending request, after zero to two wait cycles. The buffer is loaded only before each start strobe. The one deliberate exception is a second start strobe sent in the middle of a write, which exercises the ignore rule.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLK_A,
        ST_UNLK_B,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_COMMIT,
        ST_POLL
    } step_e;

    localparam logic [15:0] CMD_KEY_A      = 16'h00AA;
    localparam logic [15:0] CMD_KEY_B      = 16'h0055;
    localparam logic [15:0] CMD_BUF_SETUP  = 16'h0025;
    localparam logic [15:0] CMD_BUF_COMMIT = 16'h0029;
    localparam logic [15:0] CMD_ERASE_ARM  = 16'h0080;
    localparam logic [15:0] CMD_ERASE_GO   = 16'h0030;

endpackage

// File: rtl/flash_word_buf.sv
module flash_word_buf #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic [LIMIT_W-1:0] limit,
    output logic               last_try
);
    logic [LIMIT_W-1:0] cnt_d, cnt_q;
    logic [LIMIT_W:0]   next_cnt;

    always_comb begin
        next_cnt = {1'b0, cnt_q} + {{LIMIT_W{1'b0}}, 1'b1};
        last_try = next_cnt >= {1'b0, limit};
        cnt_d    = cnt_q;
        if (clear)     cnt_d = '0;
        else if (step) cnt_d = next_cnt[LIMIT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
    import flash_prog_pkg::*;
#(
    parameter int              ADDR_W    = 20,
    parameter int              DATA_W    = 16,
    parameter int              OFS_W     = 18,
    parameter int              MAX_WORDS = 32,
    parameter int              LIMIT_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 20'h60000,
    parameter logic [ADDR_W-1:0] KEY_A_ADR = 20'h00408,
    parameter logic [ADDR_W-1:0] KEY_B_ADR = 20'h00400,
    localparam int IDX_W = $clog2(MAX_WORDS),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               op_erase,
    input  logic [OFS_W-1:0]   byte_offset,
    input  logic [CNT_W-1:0]   word_count,
    input  logic [LIMIT_W-1:0] poll_limit,
    input  logic               buf_we,
    input  logic [IDX_W-1:0]   buf_idx,
    input  logic [DATA_W-1:0]  buf_wdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic               busy,
    output logic               done,
    output logic               error
);
    typedef struct packed {
        step_e              st;
        logic               erase;
        logic               phase2;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   idx;
        logic [ADDR_W-1:0]  dbase;
        logic [LIMIT_W-1:0] limit;
        logic               done;
        logic               err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [DATA_W-1:0] word_rd;
    logic [CNT_W-1:0]  cnt_m1;
    logic [CNT_W-1:0]  rd_sel;
    logic              poll_clear, poll_step, poll_last;
    logic              poll_ok;

    assign cnt_m1 = ctx_q.cnt - 1'b1;
    assign rd_sel = (ctx_q.st == ST_POLL) ? cnt_m1 : ctx_q.idx;

    flash_word_buf #(.DEPTH(MAX_WORDS), .DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_idx),
        .wdata (buf_wdata),
        .raddr (rd_sel[IDX_W-1:0]),
        .rdata (word_rd)
    );

    flash_poll_timer #(.LIMIT_W(LIMIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (poll_clear),
        .step     (poll_step),
        .limit    (ctx_q.limit),
        .last_try (poll_last)
    );

    assign poll_ok = ctx_q.erase ? (bus_rdata == {DATA_W{1'b1}})
                                 : (bus_rdata[7] == word_rd[7]);

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        ctx_d.err  = 1'b0;
        bus_req    = 1'b0;
        bus_we     = 1'b1;
        bus_addr   = WIN_BASE;
        bus_wdata  = '0;
        poll_clear = (ctx_q.st == ST_IDLE);
        poll_step  = 1'b0;

        case (ctx_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!op_erase && (word_count == '0 ||
                                      word_count > CNT_W'(MAX_WORDS))) begin
                        ctx_d.err = 1'b1;
                    end else begin
                        ctx_d.st     = ST_UNLK_A;
                        ctx_d.erase  = op_erase;
                        ctx_d.phase2 = 1'b0;
                        ctx_d.cnt    = word_count;
                        ctx_d.idx    = '0;
                        ctx_d.dbase  = WIN_BASE | {{(ADDR_W-OFS_W){1'b0}}, byte_offset};
                        ctx_d.limit  = poll_limit;
                    end
                end
            end
            ST_UNLK_A: begin
                bus_req   = 1'b1;
                bus_addr  = KEY_A_ADR;
                bus_wdata = DATA_W'(CMD_KEY_A);
                if (bus_ack) ctx_d.st = ST_UNLK_B;
            end
            ST_UNLK_B: begin
                bus_req   = 1'b1;
                bus_addr  = KEY_B_ADR;
                bus_wdata = DATA_W'(CMD_KEY_B);
                if (bus_ack) ctx_d.st = ST_CMD;
            end
            ST_CMD: begin
                bus_req = 1'b1;
                if (!ctx_q.erase) begin
                    bus_wdata = DATA_W'(CMD_BUF_SETUP);
                end else if (ctx_q.phase2) begin
                    bus_wdata = DATA_W'(CMD_ERASE_GO);
                end else begin
                    bus_addr  = KEY_A_ADR;
                    bus_wdata = DATA_W'(CMD_ERASE_ARM);
                end
                if (bus_ack) begin
                    if (!ctx_q.erase) begin
                        ctx_d.st = ST_COUNT;
                    end else if (ctx_q.phase2) begin
                        ctx_d.st = ST_POLL;
                    end else begin
                        ctx_d.phase2 = 1'b1;
                        ctx_d.st     = ST_UNLK_A;
                    end
                end
            end
            ST_COUNT: begin
                bus_req   = 1'b1;
                bus_wdata = {{(DATA_W-CNT_W){1'b0}}, cnt_m1};
                if (bus_ack) ctx_d.st = ST_DATA;
            end
            ST_DATA: begin
                bus_req   = 1'b1;
                bus_addr  = ctx_q.dbase + {{(ADDR_W-CNT_W-1){1'b0}}, ctx_q.idx, 1'b0};
                bus_wdata = word_rd;
                if (bus_ack) begin
                    if (ctx_q.idx == cnt_m1) ctx_d.st  = ST_COMMIT;
                    else                     ctx_d.idx = ctx_q.idx + 1'b1;
                end
            end
            ST_COMMIT: begin
                bus_req   = 1'b1;
                bus_wdata = DATA_W'(CMD_BUF_COMMIT);
                if (bus_ack) ctx_d.st = ST_POLL;
            end
            ST_POLL: begin
                bus_req = 1'b1;
                bus_we  = 1'b0;
                if (!ctx_q.erase)
                    bus_addr = ctx_q.dbase + {{(ADDR_W-CNT_W-1){1'b0}}, cnt_m1, 1'b0};
                if (bus_ack) begin
                    if (poll_ok) begin
                        ctx_d.done = 1'b1;
                        ctx_d.st   = ST_IDLE;
                    end else if (poll_last) begin
                        ctx_d.err = 1'b1;
                        ctx_d.st  = ST_IDLE;
                    end else begin
                        poll_step = 1'b1;
                    end
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, erase: 1'b0, phase2: 1'b0, cnt: '0, idx: '0,
                       dbase: '0, limit: '0, done: 1'b0, err: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy  = (ctx_q.st != ST_IDLE);
    assign done  = ctx_q.done;
    assign error = ctx_q.err;
endmodule

// File: rtl/flash_prog_checker.sv
module flash_prog_checker #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 6,
    parameter int MAX_WORDS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              op_erase,
    input logic [CNT_W-1:0]  word_count,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_bad_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !op_erase &&
         (word_count == '0 || word_count > CNT_W'(MAX_WORDS))) |=> (error && !busy));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !busy);
endmodule

bind flash_prog_engine flash_prog_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .MAX_WORDS(MAX_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .word_count(word_count), .busy(busy), .done(done), .error(error),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/flash_prog_engine_test.sv
module flash_prog_engine_test;
    localparam logic [19:0] BASE  = 20'h60000;
    localparam logic [19:0] KEY_A = 20'h00408;
    localparam logic [19:0] KEY_B = 20'h00400;

    typedef struct {
        logic        we;
        logic [19:0] addr;
        logic [15:0] data;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_erase = 1'b0;
    logic [17:0] byte_offset = '0;
    logic [5:0]  word_count = '0;
    logic [15:0] poll_limit = 16'd8;
    logic        buf_we = 1'b0;
    logic [4:0]  buf_idx = '0;
    logic [15:0] buf_wdata = '0;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata = '0;
    logic        busy, done, error;

    int vectors = 0, fails = 0, cycles = 0;
    int wait_cnt = 0, wait_tgt = 0;
    exp_t sb_q[$];
    logic [15:0] words [32];

    flash_prog_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .byte_offset(byte_offset), .word_count(word_count), .poll_limit(poll_limit),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .error(error)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic we, input logic [19:0] a, input logic [15:0] d,
                        input string req);
        exp_t e;
        e.we = we; e.addr = a; e.data = d; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic push_prefix();
        push(1'b1, KEY_A, 16'h00AA, "R2");
        push(1'b1, KEY_B, 16'h0055, "R2");
    endtask

    // monitor / responder: compares each granted access against the scoreboard
    always @(negedge clk) begin
        cycles++;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (rst_n && bus_req) begin
            if (wait_cnt < wait_tgt) begin
                wait_cnt++;
            end else begin
                wait_cnt = 0;
                wait_tgt = (wait_tgt + 1) % 3;
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected access addr", {12'h0, bus_addr}, 32'h0);
                    bus_rdata = 16'hFFFF;
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(bus_we == e.we, e.req, "direction", {31'h0, bus_we}, {31'h0, e.we});
                    check(bus_addr == e.addr, e.req, "address", {12'h0, bus_addr}, {12'h0, e.addr});
                    if (e.we)
                        check(bus_wdata == e.data, e.req, "write data",
                              {16'h0, bus_wdata}, {16'h0, e.data});
                    else
                        bus_rdata = e.data;
                end
                bus_ack = 1'b1;
            end
        end
    end

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic load(input int n, input logic [15:0] seed);
        for (int i = 0; i < n; i++) begin
            words[i] = seed ^ 16'(i * 16'h1357) ^ (i[0] ? 16'h0080 : 16'h0000);
            @(negedge clk);
            buf_we = 1'b1; buf_idx = 5'(i); buf_wdata = words[i];
        end
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic pulse_start(input logic er, input logic [17:0] ofs,
                               input logic [5:0] n, input logic [15:0] lim);
        @(negedge clk);
        op_erase = er; byte_offset = ofs; word_count = n; poll_limit = lim;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input bit exp_ok, input string req, input bool_restart);
        int n = 0;
        bit restarted = 1'b0;
        while (!(done || error) && n < 5000) begin
            if (bool_restart && !restarted && n == 6) begin
                restarted = 1'b1;
                start = 1'b1; op_erase = 1'b1; word_count = 6'd0;
                @(negedge clk);
                start = 1'b0;
            end else begin
                @(negedge clk);
            end
            n++;
        end
        check(done == exp_ok && error == !exp_ok, req, "outcome done/error",
              {30'h0, done, error}, {30'h0, exp_ok, !exp_ok});
        check(!busy, "R10", "busy at end pulse", {31'h0, busy}, 32'h0);
        @(negedge clk);
        check(!done && !error, "R10", "pulse width", {30'h0, done, error}, 32'h0);
        check(sb_q.size() == 0, req, "accesses left over", sb_q.size(), 0);
    endtask

    task automatic run_write(input logic [17:0] ofs, input int n, input int busy_polls,
                             input logic [15:0] lim, input bit exp_ok, input bit restart);
        logic [19:0] dbase, last_a;
        logic [15:0] last;
        load(n, 16'hA5C3 ^ 16'(n));
        dbase  = BASE | {2'b00, ofs};
        last   = words[n-1];
        last_a = dbase + 20'(2 * (n - 1));
        push_prefix();
        push(1'b1, BASE, 16'h0025, "R3");
        push(1'b1, BASE, 16'(n - 1), "R3");
        for (int i = 0; i < n; i++) push(1'b1, dbase + 20'(2 * i), words[i], "R3");
        push(1'b1, BASE, 16'h0029, "R3");
        for (int k = 0; k < busy_polls; k++) push(1'b0, last_a, last ^ 16'h1280, "R4");
        if (exp_ok) push(1'b0, last_a, last ^ 16'h0301, "R4");
        pulse_start(1'b0, ofs, 6'(n), lim);
        wait_end(exp_ok, exp_ok ? "R4" : "R7", restart);
    endtask

    task automatic run_erase(input int busy_polls, input logic [15:0] lim, input bit exp_ok);
        push_prefix();
        push(1'b1, KEY_A, 16'h0080, "R5");
        push_prefix();
        push(1'b1, BASE, 16'h0030, "R5");
        for (int k = 0; k < busy_polls; k++) push(1'b0, BASE, 16'hFF7F, "R5");
        if (exp_ok) push(1'b0, BASE, 16'hFFFF, "R5");
        pulse_start(1'b1, 18'h0, 6'd0, lim);
        wait_end(exp_ok, exp_ok ? "R5" : "R7", 1'b0);
    endtask

    task automatic run_reject(input logic [5:0] n);
        pulse_start(1'b0, 18'h0, n, 16'd4);
        check(error && !busy, "R6", "reject error pulse", {30'h0, error, busy}, 32'h2);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!bus_req && !busy, "R6", "no access after reject",
                  {30'h0, bus_req, busy}, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !bus_req && !done && !error, "R1", "reset outputs",
              {28'h0, busy, bus_req, done, error}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !bus_req, "R1", "idle after reset", {30'h0, busy, bus_req}, 32'h0);

        run_write(18'h00100, 4, 2, 16'd8, 1'b1, 1'b0);   // R3 R4
        run_write(18'h20010, 3, 0, 16'd8, 1'b1, 1'b0);   // R3 offset overlapping window bit
        run_write(18'h00000, 1, 1, 16'd8, 1'b1, 1'b0);   // R3 single word
        run_write(18'h00400, 32, 3, 16'd8, 1'b1, 1'b0);  // R3 full buffer
        run_write(18'h00020, 5, 1, 16'd8, 1'b1, 1'b1);   // R9 start ignored while busy
        run_reject(6'd0);                                // R6 zero count
        run_reject(6'd33);                               // R6 count above buffer
        run_write(18'h00040, 2, 3, 16'd3, 1'b0, 1'b0);   // R7 poll timeout
        run_erase(2, 16'd8, 1'b1);                       // R5 erase
        run_erase(4, 16'd4, 1'b0);                       // R7 erase timeout
        run_write(18'h3FFFE, 2, 0, 16'd8, 1'b1, 1'b0);   // R8 varied waits, wrap
        finish_run();
    end
endmodule